// File: doc/BRIEF.md
# Coprocessor Sleep Dependency Gate

This block decides when a coprocessor clock domain may be put to sleep by hardware, given that its automatic sleep depends on the main processor domain. Each of the two domains has a 2-bit transition-control field, written through a plain write-enable/data pair. A field value of 0x3 selects hardware-automatic transitions. Every other value leaves the domain under software control, and hardware never asks for idle.

A hardware idle request for the coprocessor is raised only when four conditions hold together: both fields hold 0x3, the processor domain reports standby, and the coprocessor reports that it is ready to idle. A separate status output flags the case where the only missing condition is the processor standby. All pins are plain control and status levels with no flow control, so no valid/ready interface applies. Both outputs are registered and follow their inputs by one clock edge.

Top module: `sleep_dep_gate`

## Requirements
- R1: After reset both transition fields read as 0x0, so with standby and idle-ready both high, the idle request and the blocked status stay 0.
- R2: A field is loaded from its write data on a clock edge where its write enable is high. The new value first affects the outputs registered on the following edge. A field without write enable keeps its value.
- R3: The idle request goes to 1 on the edge after a cycle in which both fields are 0x3 (binary 11), processor standby is 1 and coprocessor idle-ready is 1.
- R4: If the coprocessor field is 0x0, 0x1 or 0x2, the idle request is 0 on the next edge.
- R5: If the processor field is 0x0, 0x1 or 0x2, the idle request is 0 on the next edge, even when the coprocessor field is 0x3.
- R6: When processor standby is low, the idle request is 0 on the next edge.
- R7: When coprocessor idle-ready is low, the idle request is 0 on the next edge.
- R8: The blocked status is 1 on the edge after a cycle in which both fields are 0x3, idle-ready is 1 and standby is 0. Otherwise it is 0.
- R9: The idle request and the blocked status are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proc_mode_we | input | 1 | Write enable for the processor-domain field |
| proc_mode_wdata | input | 2 | Write data for the processor-domain field |
| cop_mode_we | input | 1 | Write enable for the coprocessor-domain field |
| cop_mode_wdata | input | 2 | Write data for the coprocessor-domain field |
| proc_standby | input | 1 | Processor domain is in standby |
| cop_idle_ready | input | 1 | Coprocessor is ready to idle |
| cop_idle_req | output | 1 | Registered hardware idle request for the coprocessor |
| dep_blocked | output | 1 | Registered status: idle is held off only by the processor standby |

## Verification
The bench targets the one-edge write latency. A design that applied a field write in the same cycle would raise the request one edge early. It covers a processor field other than 0x3 while the coprocessor field is 0x3; a gate that looked only at the coprocessor field would then idle without its dependency met. It drops standby with everything else still true, where a slow or sticky request would stay high one edge too long and the blocked status would fail to rise. Randomly mixed field values, including the non-automatic codes, check that the request and the blocked status never overlap.

// File: rtl/sleep_dep_pkg.sv
package sleep_dep_pkg;
  localparam int unsigned MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    TC_OFF    = 2'b00,
    TC_SW_SLP = 2'b01,
    TC_SW_WK  = 2'b10,
    TC_HW_AUTO = 2'b11
  } tc_mode_e;
  localparam int unsigned N_DOM = 2;
  localparam int unsigned DOM_PROC = 0;
  localparam int unsigned DOM_COP  = 1;
endpackage

// File: rtl/sdg_mode_reg.sv
module sdg_mode_reg
  import sleep_dep_pkg::*;
#(
  parameter tc_mode_e RST_VAL = TC_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  output tc_mode_e          mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode <= RST_VAL;
    else if (we) mode <= tc_mode_e'(wdata);
  end

  // R2: an unwritten field holds
  p_hold_unwritten_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mode));
  // R2: a write lands on the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode == $past(wdata)));
endmodule

// File: rtl/sdg_dep_eval.sv
module sdg_dep_eval
  import sleep_dep_pkg::*;
(
  input  tc_mode_e proc_mode,
  input  tc_mode_e cop_mode,
  input  logic     proc_standby,
  input  logic     cop_idle_ready,
  output logic     want_idle,
  output logic     only_dep_missing
);
  logic both_auto;
  always_comb begin
    both_auto        = (proc_mode == TC_HW_AUTO) && (cop_mode == TC_HW_AUTO);
    want_idle        = both_auto && cop_idle_ready && proc_standby;
    only_dep_missing = both_auto && cop_idle_ready && !proc_standby;
  end
endmodule

// File: rtl/sleep_dep_gate.sv
module sleep_dep_gate
  import sleep_dep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_mode_we,
  input  logic [MODE_W-1:0] proc_mode_wdata,
  input  logic              cop_mode_we,
  input  logic [MODE_W-1:0] cop_mode_wdata,
  input  logic              proc_standby,
  input  logic              cop_idle_ready,
  output logic              cop_idle_req,
  output logic              dep_blocked
);
  logic [N_DOM-1:0]             dom_we;
  logic [N_DOM-1:0][MODE_W-1:0] dom_wdata;
  tc_mode_e                     dom_mode [N_DOM];

  assign dom_we[DOM_PROC]    = proc_mode_we;
  assign dom_we[DOM_COP]     = cop_mode_we;
  assign dom_wdata[DOM_PROC] = proc_mode_wdata;
  assign dom_wdata[DOM_COP]  = cop_mode_wdata;

  // R1: both fields come out of reset as no-automatic
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    sdg_mode_reg #(.RST_VAL(TC_OFF)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dom_we[d]),
      .wdata (dom_wdata[d]),
      .mode  (dom_mode[d])
    );
  end

  logic want_idle, only_dep_missing;
  sdg_dep_eval u_eval (
    .proc_mode        (dom_mode[DOM_PROC]),
    .cop_mode         (dom_mode[DOM_COP]),
    .proc_standby     (proc_standby),
    .cop_idle_ready   (cop_idle_ready),
    .want_idle        (want_idle),
    .only_dep_missing (only_dep_missing)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cop_idle_req <= 1'b0;
      dep_blocked  <= 1'b0;
    end else begin
      cop_idle_req <= want_idle;
      dep_blocked  <= only_dep_missing;
    end
  end

  // R3, R4, R5: a request needs both fields automatic one edge earlier
  p_req_needs_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cop_idle_req |-> ($past(dom_mode[DOM_COP]) == TC_HW_AUTO) &&
                     ($past(dom_mode[DOM_PROC]) == TC_HW_AUTO));
  // R6: standby low removes the request on the next edge
  p_standby_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_standby |=> !cop_idle_req);
  // R7: not ready means no request on the next edge
  p_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cop_idle_ready |=> !cop_idle_req);
  // R8: blocked status only while standby was low
  p_blocked_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dep_blocked |-> !$past(proc_standby) && $past(cop_idle_ready));
  // R9: exclusive outputs
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cop_idle_req, dep_blocked}));
endmodule

// File: tb/sleep_dep_gate_tb.sv
module sleep_dep_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proc_mode_we = 1'b0, cop_mode_we = 1'b0;
  logic [1:0] proc_mode_wdata = 2'b00, cop_mode_wdata = 2'b00;
  logic proc_standby = 1'b1, cop_idle_ready = 1'b1;
  logic cop_idle_req, dep_blocked;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [1:0] m_proc = 2'b00, m_cop = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_dep_gate dut_i (
    .clk(clk), .rst_n(rst_n),
    .proc_mode_we(proc_mode_we), .proc_mode_wdata(proc_mode_wdata),
    .cop_mode_we(cop_mode_we), .cop_mode_wdata(cop_mode_wdata),
    .proc_standby(proc_standby), .cop_idle_ready(cop_idle_ready),
    .cop_idle_req(cop_idle_req), .dep_blocked(dep_blocked)
  );

  function automatic logic exp_req(logic [1:0] p, logic [1:0] c, logic sb, logic rdy);
    return (p == 2'b11) && (c == 2'b11) && sb && rdy;
  endfunction
  function automatic logic exp_blk(logic [1:0] p, logic [1:0] c, logic sb, logic rdy);
    return (p == 2'b11) && (c == 2'b11) && !sb && rdy;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(logic pwe, logic [1:0] pd, logic cwe, logic [1:0] cd,
                      logic sb, logic rdy, string tag);
    logic er, eb;
    @(negedge clk);
    proc_mode_we = pwe; proc_mode_wdata = pd;
    cop_mode_we = cwe;  cop_mode_wdata = cd;
    proc_standby = sb;  cop_idle_ready = rdy;
    er = exp_req(m_proc, m_cop, sb, rdy);
    eb = exp_blk(m_proc, m_cop, sb, rdy);
    @(posedge clk);
    #1;
    if (pwe) m_proc = pd;
    if (cwe) m_cop = cd;
    check(tag, cop_idle_req, er, "idle_req");
    check(tag, dep_blocked, eb, "blocked");
    check("R9", cop_idle_req & dep_blocked, 1'b0, "overlap");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", cop_idle_req, 1'b0, "idle_req in reset");
    @(negedge clk) rst_n = 1'b1;
    // R1: reset fields are 0x0, everything else favourable
    step(0, 2'b00, 0, 2'b00, 1, 1, "R1");
    step(0, 2'b00, 0, 2'b00, 0, 1, "R1");
    // R2: write both to automatic; request only one edge later
    step(1, 2'b11, 1, 2'b11, 1, 1, "R2");
    step(0, 2'b00, 0, 2'b00, 1, 1, "R3");
    step(0, 2'b00, 0, 2'b00, 1, 1, "R3");
    // R6, R8: standby drops, request falls, blocked rises
    step(0, 2'b00, 0, 2'b00, 0, 1, "R6");
    step(0, 2'b00, 0, 2'b00, 1, 1, "R3");
    // R7: not ready
    step(0, 2'b00, 0, 2'b00, 1, 0, "R7");
    step(0, 2'b00, 0, 2'b00, 0, 0, "R8");
    // R4: coprocessor field not automatic
    for (int v = 0; v < 3; v++) begin
      step(0, 2'b00, 1, 2'(v), 1, 1, "R4");
      step(0, 2'b00, 0, 2'b00, 1, 1, "R4");
      step(0, 2'b00, 0, 2'b00, 0, 1, "R8");
    end
    step(0, 2'b00, 1, 2'b11, 1, 1, "R2");
    // R5: processor field not automatic, coprocessor automatic
    for (int v = 0; v < 3; v++) begin
      step(1, 2'(v), 0, 2'b00, 1, 1, "R5");
      step(0, 2'b00, 0, 2'b00, 1, 1, "R5");
      step(0, 2'b00, 0, 2'b00, 0, 1, "R8");
    end
    step(1, 2'b11, 0, 2'b00, 1, 1, "R2");
    step(0, 2'b00, 0, 2'b00, 0, 1, "R8");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic pwe, cwe, sb, rdy;
      logic [1:0] pd, cd;
      pwe = ($urandom % 8) == 0;
      cwe = ($urandom % 8) == 0;
      pd  = (($urandom % 3) != 0) ? 2'b11 : 2'($urandom);
      cd  = (($urandom % 3) != 0) ? 2'b11 : 2'($urandom);
      sb  = ($urandom % 4) != 0;
      rdy = ($urandom % 4) != 0;
      step(pwe, pd, cwe, cd, sb, rdy, "R3");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule